// File: doc/BRIEF.md
# DMA Request Channel Multiplexer

This block sits between the peripheral request lines of a chip and the channels of a DMA engine. It takes up to 128 request inputs and gives each DMA channel one request output. Each channel has its own configuration register. The register holds an enable bit and a 7-bit source code, and the code picks which input line drives that channel. A handful of codes have fixed meanings. Code 0 selects nothing. The two highest codes are sources that are always active. A set of reserved codes never produce a request.

The first four channels can also be paced by a periodic trigger. A trigger-control register holds one enable bit per channel, at the bit position equal to the channel number. When that bit is set, the channel's selected request reaches the output only in the cycles where that channel's trigger pulse input is high. Otherwise the selected request passes straight through with no register on the path.

Software reads and writes the registers over a simple bus with a write strobe and an address. Reads are combinational. The reset is asynchronous and active low. Its release is synchronised inside the block, and reset clears every register to zero, which leaves all channels disabled.

Top module: `dma_req_router`

## Requirements
- R1: While reset is applied and after it is released, every configuration register and the trigger-control register read as zero, and every channel request output is low.
- R2: Addresses 0 to 7 each hold one channel's configuration byte: bit 7 is the enable and bits 6:0 are the source code. A write with the strobe high stores the whole byte at the clock edge, and a read of the same address returns it unchanged.
- R3: A channel that is enabled and holds an ordinary source code s drives its output from request input s in the same cycle, with no register on the path, whenever its trigger bit is clear.
- R4: A channel whose enable bit is 0 keeps its output low whatever its source code and the request inputs.
- R5: An enabled channel with source code 0 keeps its output low even when all request inputs are high.
- R6: An enabled channel with source code 126 or 127 drives its output high in every cycle, even when all request inputs are low, unless trigger gating applies.
- R7: The reserved codes 17-22, 27-32, 35-40, 57-58, 82-85, 89, 92-97, 106-109, 114-117 and 122-125 produce no request on an enabled channel, even when the matching input is high.
- R8: Address 8 is the trigger-control register, with bit c belonging to channel c. Only bits 3:0 can be stored. Bits 7:4 ignore writes and always read as zero. Addresses 9 to 15 read as zero, and writes to them change no register.
- R9: On a channel from 0 to 3 whose trigger bit is set, the output equals the selected request ANDed with that channel's trigger pulse input in the same cycle. When the pulse input is low, the output is low.
- R10: Channels are independent. Several channels may select the same input, and each one gives the result its own register calls for.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-7 channel configuration, 8 trigger control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| src_req | input | 128 | Peripheral request lines, indexed by source code |
| trig_pulse | input | 4 | Periodic trigger pulses, one for each of channels 0 to 3 |
| chan_req | output | 8 | Request output for each DMA channel |

## Verification
The assertions assume that `reg_addr`, `reg_wdata` and `reg_we` are stable and known around each rising edge. They also assume that the request and trigger inputs are free of X, since the output checks compare those inputs with the outputs in the same cycle. The bench changes every input only at the falling edge and drives each bit to a defined value on every step, including out-of-range addresses. It does not assert a write until the synchronised reset has been released.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;

  // Classification of a register bus address.
  typedef enum logic [1:0] {
    ACC_CFG  = 2'd0,
    ACC_TRIG = 2'd1,
    ACC_NONE = 2'd2
  } acc_kind_e;

  // Source codes that have no peripheral attached.
  function automatic logic code_reserved(input int unsigned code);
    return (code inside {[17:22], [27:32], [35:40], [57:58], [82:85], 89,
                         [92:97], [106:109], [114:117], [122:125]});
  endfunction

  // The two highest codes of the source space are always active.
  function automatic logic code_always_on(input int unsigned code,
                                          input int unsigned n_src);
    return (code >= n_src - 2);
  endfunction

endpackage

// File: rtl/dmarr_rst_sync.sv
module dmarr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dmarr_regfile.sv
module dmarr_regfile
  import dmarr_pkg::*;
#(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned N_TRIG_CH = 4,
  parameter int unsigned SEL_W     = 7,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned DATA_W   = SEL_W + 1,
  localparam int unsigned TRIG_ADR = N_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [N_CH-1:0]      cfg_en,
  output logic [SEL_W-1:0]     cfg_sel [N_CH],
  output logic [N_TRIG_CH-1:0] trig_en
);

  acc_kind_e kind;
  logic [N_CH-1:0]      cfg_wr;
  logic                 trig_wr;
  logic [N_CH-1:0]      en_d;
  logic [SEL_W-1:0]     sel_d [N_CH];
  logic [N_TRIG_CH-1:0] trig_d;

  // Address decode
  always_comb begin
    if (int'(addr) < N_CH)         kind = ACC_CFG;
    else if (int'(addr) == TRIG_ADR) kind = ACC_TRIG;
    else                           kind = ACC_NONE;
  end

  assign trig_wr = we && (kind == ACC_TRIG);

  // Next state of each channel configuration register
  for (genvar c = 0; c < N_CH; c++) begin : g_cfg
    always_comb begin
      cfg_wr[c] = we && (kind == ACC_CFG) && (int'(addr) == c);
      en_d[c]   = wdata[DATA_W-1];
      sel_d[c]  = wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_en[c]  <= 1'b0;
        cfg_sel[c] <= '0;
      end else if (cfg_wr[c]) begin
        cfg_en[c]  <= en_d[c];
        cfg_sel[c] <= sel_d[c];
      end
    end

    AST_CFG_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(addr) == c) |=> ({cfg_en[c], cfg_sel[c]} == $past(wdata))); // R2
  end

  // Only the triggerable channels have storage in the trigger register
  always_comb begin
    trig_d = wdata[N_TRIG_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_en <= '0;
    else if (trig_wr) trig_en <= trig_d;
  end

  AST_TRIG_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == TRIG_ADR) |=> (trig_en == $past(wdata[N_TRIG_CH-1:0]))); // R8

  AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) > TRIG_ADR) |=> ($stable(trig_en) && $stable(cfg_en))); // R8

  // Combinational read
  always_comb begin
    rdata = '0;
    unique case (kind)
      ACC_CFG: begin
        for (int c = 0; c < N_CH; c++) begin
          if (int'(addr) == c) rdata = {cfg_en[c], cfg_sel[c]};
        end
      end
      ACC_TRIG: rdata[N_TRIG_CH-1:0] = trig_en;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmarr_chan_sel.sv
module dmarr_chan_sel
  import dmarr_pkg::*;
#(
  parameter int unsigned N_SRC = 128,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_req,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_req
);

  logic picked;
  logic no_src;
  logic fixed_on;

  always_comb begin
    picked   = src_req[sel];
    no_src   = (sel == '0) || code_reserved(int'(sel));
    fixed_on = code_always_on(int'(sel), N_SRC);
    if (!en || no_src) sel_req = 1'b0;
    else if (fixed_on) sel_req = 1'b1;
    else               sel_req = picked;
  end

endmodule

// File: rtl/dmarr_trig_gate.sv
module dmarr_trig_gate (
  input  logic sel_req,
  input  logic trig_en,
  input  logic trig_pulse,
  output logic chan_req
);

  always_comb begin
    if (trig_en) chan_req = sel_req && trig_pulse;
    else         chan_req = sel_req;
  end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmarr_pkg::*;
#(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned N_SRC     = 128,
  parameter int unsigned N_TRIG_CH = 4,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned SEL_W    = $clog2(N_SRC),
  localparam int unsigned DATA_W   = SEL_W + 1,
  localparam int unsigned ADDR_W   = $clog2(N_CH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [N_SRC-1:0]     src_req,
  input  logic [N_TRIG_CH-1:0] trig_pulse,
  output logic [N_CH-1:0]      chan_req
);

  logic                 rst_sync_n;
  logic [N_CH-1:0]      cfg_en;
  logic [SEL_W-1:0]     cfg_sel [N_CH];
  logic [N_TRIG_CH-1:0] trig_en;
  logic [N_CH-1:0]      sel_req;

  dmarr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmarr_regfile #(
    .N_CH      (N_CH),
    .N_TRIG_CH (N_TRIG_CH),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W)
  ) u_regfile (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .cfg_en  (cfg_en),
    .cfg_sel (cfg_sel),
    .trig_en (trig_en)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dmarr_chan_sel #(.N_SRC(N_SRC)) u_sel (
      .src_req (src_req),
      .en      (cfg_en[c]),
      .sel     (cfg_sel[c]),
      .sel_req (sel_req[c])
    );

    if (c < N_TRIG_CH) begin : g_trig
      dmarr_trig_gate u_gate (
        .sel_req    (sel_req[c]),
        .trig_en    (trig_en[c]),
        .trig_pulse (trig_pulse[c]),
        .chan_req   (chan_req[c])
      );

      AST_TRIG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (trig_en[c] && !trig_pulse[c]) |-> !chan_req[c]); // R9
    end else begin : g_plain
      assign chan_req[c] = sel_req[c];
    end

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !cfg_en[c] |-> !chan_req[c]); // R4

    AST_CODE0_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_sel[c] == '0) |-> !chan_req[c]); // R5

    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
      code_reserved(int'(cfg_sel[c])) |-> !chan_req[c]); // R7

    AST_ALWAYS_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_en[c] && int'(cfg_sel[c]) >= N_SRC - 2 && !(c < N_TRIG_CH && trig_en[c % N_TRIG_CH]))
        |-> chan_req[c]); // R6
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (chan_req == '0)); // R1

endmodule

// File: tb/dma_req_router_tb.sv
`timescale 1ns/1ps
module dma_req_router_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [3:0]   reg_addr;
  logic [7:0]   reg_wdata;
  logic [7:0]   reg_rdata;
  logic [127:0] src_req;
  logic [3:0]   trig_pulse;
  logic [7:0]   chan_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_cfg [8];
  logic [3:0] m_trig;

  always #2 clk = ~clk;

  dma_req_router u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .src_req    (src_req),
    .trig_pulse (trig_pulse),
    .chan_req   (chan_req)
  );

  function automatic bit rsv(input int s);
    case (s)
      17,18,19,20,21,22, 27,28,29,30,31,32, 35,36,37,38,39,40, 57,58,
      82,83,84,85, 89, 92,93,94,95,96,97, 106,107,108,109,
      114,115,116,117, 122,123,124,125: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_req(input int c);
    bit r;
    int s;
    s = int'(m_cfg[c][6:0]);
    if (!m_cfg[c][7] || s == 0 || rsv(s)) r = 0;
    else if (s >= 126) r = 1;
    else r = src_req[s];
    if (c < 4 && m_trig[c]) r = r & trig_pulse[c];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a < 8) return m_cfg[a];
    if (a == 8) return {4'b0, m_trig};
    return 8'h00;
  endfunction

  task automatic check_outs(input string tag);
    for (int c = 0; c < 8; c++) begin
      n_vec++;
      if (chan_req[c] !== exp_req(c)) begin
        n_bad++;
        $display("FAIL %s ch%0d chan_req actual=%b expected=%b", tag, c, chan_req[c], exp_req(c));
      end
    end
  endtask

  task automatic check_rd(input int a, input string tag);
    @(negedge clk);
    reg_addr = 4'(a);
    #0.5;
    n_vec++;
    if (reg_rdata !== exp_rd(a)) begin
      n_bad++;
      $display("FAIL %s addr%0d rdata actual=%h expected=%h", tag, a, reg_rdata, exp_rd(a));
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 8) m_cfg[a] = d;
    else if (a == 8) m_trig = d[3:0];
  endtask

  task automatic step_inputs(input logic [127:0] s, input logic [3:0] p, input string tag);
    @(negedge clk);
    src_req = s; trig_pulse = p;
    #0.5;
    check_outs(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int a;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 8; c++) m_cfg[c] = 8'h00;
    m_trig = 4'h0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_req = '1; trig_pulse = '1;
    repeat (3) @(negedge clk);
    check_outs("R1 in reset");
    for (int i = 0; i < 16; i++) check_rd(i, "R1 reset read");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R1 after release");

    // R2 write/read of config bytes
    for (int c = 0; c < 8; c++) wr(c, 8'(8'h80 | (c * 13 + 1)));
    for (int c = 0; c < 8; c++) check_rd(c, "R2 readback");

    // R3 ordinary routing, R10 shared source
    wr(0, 8'h85); wr(1, 8'h85); wr(5, 8'h85);
    step_inputs(128'h0, 4'h0, "R3 R10 src low");
    step_inputs(128'h20, 4'h0, "R3 R10 src5 high");
    // R4 disabled
    wr(2, 8'h05);
    step_inputs('1, 4'hf, "R4 disabled");
    // R5 code 0
    wr(3, 8'h80);
    step_inputs('1, 4'hf, "R5 code0");
    // R6 always-on
    wr(6, 8'h8e | 8'h70); wr(7, 8'hff);
    step_inputs('0, 4'h0, "R6 always-on");
    // R7 reserved codes
    wr(4, 8'h80 | 8'd17); step_inputs('1, 4'h0, "R7 code17");
    wr(4, 8'h80 | 8'd89); step_inputs('1, 4'h0, "R7 code89");
    wr(4, 8'h80 | 8'd125); step_inputs('1, 4'h0, "R7 code125");
    // R8 trigger register and unmapped addresses
    wr(8, 8'hff);
    check_rd(8, "R8 upper bits read zero");
    wr(12, 8'hff); wr(15, 8'h00);
    for (int i = 0; i < 16; i++) check_rd(i, "R8 unmapped write ignored");
    // R9 gating on ch0 with source always-on and ordinary
    wr(0, 8'hff); wr(1, 8'h85);
    step_inputs('1, 4'h0, "R9 no pulse");
    step_inputs('1, 4'h3, "R9 pulse");
    step_inputs('0, 4'h3, "R9 pulse no request");

    // Constrained random
    for (int it = 0; it < 3000; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        a = $urandom_range(0, 15);
        d = 8'($urandom);
        case ($urandom_range(0, 5))
          0: d[6:0] = 7'd0;
          1: d[6:0] = 7'(126 + $urandom_range(0, 1));
          2: d[6:0] = 7'(17 + $urandom_range(0, 5));
          default: ;
        endcase
        wr(a, d);
      end
      step_inputs({$urandom, $urandom, $urandom, $urandom}, 4'($urandom), "R3 R9 R10 random");
      if ($urandom_range(0, 3) == 0) check_rd($urandom_range(0, 15), "R2 R8 random read");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule